// File: doc/BRIEF.md
# Boot-Load Entry Qualifier with Serial Rate Detection

This block decides, from a handful of strap pins, whether a controller enters its boot-load state, and whether that load happens over the serial line or over the parallel port. The load state begins only when the reset pin is high while the active-low program-store strobe is pulled low. From then on, the state is held for as long as the reset pin stays high. The two port-select straps, both high, pick the serial path. Any other strap combination picks the parallel path.

On the serial path, the block measures the width of each start bit on the receive line, counted in clock cycles. It compares that width with a fixed list of candidate bit periods, each derived from the clock-frequency parameter. When the width matches a candidate, the block decodes the rest of the character at that rate. It locks only when the character is a carriage return (0x0D) with a proper stop bit. Once locked, it reports the rate index to the UART divider that follows it.

Top module: `abd_bootstrap`

## Requirements
- R1: After reset, load_mode, serial_mode, parallel_mode and locked are 0 and baud_idx is 0.
- R2: load_mode rises only when rst_pin is 1 and psen_n is 0 at the same time; rst_pin high with psen_n high does not start it.
- R3: Once set, load_mode stays 1 while rst_pin stays 1, even after psen_n returns high; load_mode clears when rst_pin goes low.
- R4: In load mode, serial_mode is 1 exactly when strap_hi and strap_lo are both 1, and parallel_mode is 1 for every other strap combination; outside load mode both flags are 0. The two flags are never 1 together.
- R5: While serial_mode is 0, traffic on rx_in has no effect: locked stays 0.
- R6: A start-bit width within ±3% of a candidate period selects that candidate. The index encoding is 0=300, 1=1200, 2=2400, 3=9600, 4=19200, 5=57600 bps, and each period is CLK_HZ/rate, rounded.
- R7: After a width match, the frame (8 data bits, LSB first, one stop bit) is sampled at mid-bit at the matched rate. The block locks only if the byte equals 0x0D. Any other byte causes a rearm, and a later carriage return can still lock.
- R8: A start-bit width outside every candidate window never locks.
- R9: While locked and in serial mode, locked and baud_idx hold their values whatever arrives on rx_in.
- R10: When serial mode ends (including the exit from load mode), locked returns to 0 and baud_idx to 0 on the next cycle.
- R11: A carriage return whose stop bit samples low does not lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| rst_pin | input | 1 | Device reset pin, active high |
| psen_n | input | 1 | Program-store strobe pin, active low |
| strap_hi | input | 1 | Upper port-select strap |
| strap_lo | input | 1 | Lower port-select strap |
| rx_in | input | 1 | Asynchronous serial receive line, idle high |
| load_mode | output | 1 | Boot-load state active |
| serial_mode | output | 1 | Serial load path selected |
| parallel_mode | output | 1 | Parallel load path selected |
| baud_idx | output | 3 | Locked rate index (encoding per R6) |
| locked | output | 1 | Carriage return received at a candidate rate |

## Verification
The hardest cases to reach from the ports are the edges of the tolerance window and the paths where a width matches but the character is then rejected. To drive these, the bench sends whole frames at bit widths chosen to sit just inside and just outside the ±3% window of the 9600 bps candidate. It also sends a wrong byte and a carriage return with a low stop bit, each at a matching width. The clock-frequency parameter is set low in the bench, so that even the 300 bps frame fits in a short run.

// File: rtl/abd_pkg.sv
package abd_pkg;
  localparam int IDX_W     = 3;
  localparam int MAX_RATES = 6;

  function automatic int unsigned rate_bps(input int idx);
    case (idx)
      0:       return 300;
      1:       return 1200;
      2:       return 2400;
      3:       return 9600;
      4:       return 19200;
      default: return 57600;
    endcase
  endfunction

  function automatic int unsigned rate_period(input int unsigned clk_hz, input int idx);
    return (clk_hz + rate_bps(idx) / 2) / rate_bps(idx);
  endfunction

  typedef enum logic [2:0] {
    ST_ARM, ST_IDLE, ST_START, ST_DATA, ST_LOCK
  } det_state_t;
endpackage

// File: rtl/abd_sync.sv
module abd_sync #(
  parameter int          W    = 1,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= INIT;
      s2_q <= INIT;
    end else begin
      s1_q <= d_in;
      s2_q <= s1_q;
    end
  end

  assign d_out = s2_q;
endmodule

// File: rtl/abd_entry.sv
module abd_entry (
  input  logic clk,
  input  logic rst_n,
  input  logic rst_s,
  input  logic psen_n_s,
  input  logic hi_s,
  input  logic lo_s,
  output logic load_mode,
  output logic serial_mode,
  output logic parallel_mode
);
  logic load_q, ser_q, par_q;
  logic load_d, ser_d, par_d, straps_up;

  always_comb begin
    straps_up = hi_s & lo_s;
    load_d    = rst_s & (load_q | ~psen_n_s);
    ser_d     = load_d & straps_up;
    par_d     = load_d & ~straps_up;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= 1'b0;
      ser_q  <= 1'b0;
      par_q  <= 1'b0;
    end else begin
      load_q <= load_d;
      ser_q  <= ser_d;
      par_q  <= par_d;
    end
  end

  assign load_mode     = load_q;
  assign serial_mode   = ser_q;
  assign parallel_mode = par_q;
endmodule

// File: rtl/abd_detect.sv
module abd_detect #(
  parameter int unsigned CLK_HZ    = 11_059_200,
  parameter int          NUM_RATES = 6,
  parameter int          TOL_PCT   = 3,
  parameter int          CW        = 17
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       enable,
  input  logic                       rx,
  output logic                       locked,
  output logic [abd_pkg::IDX_W-1:0]  baud_idx
);
  import abd_pkg::*;

  det_state_t       st_q, st_d;
  logic [CW-1:0]    cnt_q, cnt_d, per_q, per_d;
  logic [3:0]       bit_q, bit_d;
  logic [7:0]       shf_q, shf_d;
  logic [IDX_W-1:0] cand_q, cand_d, idx_q, idx_d;
  logic             lock_q, lock_d;

  logic [NUM_RATES-1:0] hit;
  logic [IDX_W-1:0]     pick_idx;
  logic [CW-1:0]        pick_per;

  for (genvar g = 0; g < NUM_RATES; g++) begin : g_win
    localparam int P = int'(rate_period(CLK_HZ, g));
    localparam int T = P * TOL_PCT / 100;
    assign hit[g] = (cnt_q >= CW'(P - T)) && (cnt_q <= CW'(P + T));
  end

  always_comb begin
    pick_idx = '0;
    pick_per = '0;
    for (int i = 0; i < NUM_RATES; i++) begin
      if (hit[i]) begin
        pick_idx = IDX_W'(i);
        pick_per = CW'(rate_period(CLK_HZ, i));
      end
    end
  end

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    per_d  = per_q;
    bit_d  = bit_q;
    shf_d  = shf_q;
    cand_d = cand_q;
    idx_d  = idx_q;
    lock_d = lock_q;
    if (!enable) begin
      st_d   = ST_ARM;
      lock_d = 1'b0;
      idx_d  = '0;
    end else begin
      case (st_q)
        ST_ARM:  if (rx) st_d = ST_IDLE;
        ST_IDLE: if (!rx) begin
          st_d  = ST_START;
          cnt_d = CW'(1);
        end
        ST_START: begin
          if (!rx) begin
            if (cnt_q != '1) cnt_d = cnt_q + 1'b1;
          end else if (|hit) begin
            st_d   = ST_DATA;
            per_d  = pick_per;
            cand_d = pick_idx;
            cnt_d  = pick_per >> 1;
            bit_d  = '0;
          end else begin
            st_d = ST_ARM;
          end
        end
        ST_DATA: begin
          if (cnt_q == '0) begin
            if (bit_q == 4'd8) begin
              if (rx && shf_q == 8'h0D) begin
                st_d   = ST_LOCK;
                lock_d = 1'b1;
                idx_d  = cand_q;
              end else begin
                st_d = ST_ARM;
              end
            end else begin
              shf_d = {rx, shf_q[7:1]};
              bit_d = bit_q + 1'b1;
              cnt_d = per_q - 1'b1;
            end
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_ARM;
      cnt_q  <= '0;
      per_q  <= '0;
      bit_q  <= '0;
      shf_q  <= '0;
      cand_q <= '0;
      idx_q  <= '0;
      lock_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      per_q  <= per_d;
      bit_q  <= bit_d;
      shf_q  <= shf_d;
      cand_q <= cand_d;
      idx_q  <= idx_d;
      lock_q <= lock_d;
    end
  end

  assign locked   = lock_q;
  assign baud_idx = idx_q;
endmodule

// File: rtl/abd_bootstrap.sv
module abd_bootstrap #(
  parameter int unsigned CLK_HZ    = 11_059_200,
  parameter int          NUM_RATES = 6,
  parameter int          TOL_PCT   = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rst_pin,
  input  logic                      psen_n,
  input  logic                      strap_hi,
  input  logic                      strap_lo,
  input  logic                      rx_in,
  output logic                      load_mode,
  output logic                      serial_mode,
  output logic                      parallel_mode,
  output logic [abd_pkg::IDX_W-1:0] baud_idx,
  output logic                      locked
);
  localparam int SLOW_PER = int'(abd_pkg::rate_period(CLK_HZ, 0));
  localparam int CW       = $clog2(SLOW_PER * 2 + 2);

  logic [4:0] pins_s;

  abd_sync #(.W(5), .INIT(5'b11110)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  ({rx_in, strap_lo, strap_hi, psen_n, rst_pin}),
    .d_out (pins_s)
  );

  abd_entry u_entry (
    .clk           (clk),
    .rst_n         (rst_n),
    .rst_s         (pins_s[0]),
    .psen_n_s      (pins_s[1]),
    .hi_s          (pins_s[2]),
    .lo_s          (pins_s[3]),
    .load_mode     (load_mode),
    .serial_mode   (serial_mode),
    .parallel_mode (parallel_mode)
  );

  abd_detect #(
    .CLK_HZ    (CLK_HZ),
    .NUM_RATES (NUM_RATES),
    .TOL_PCT   (TOL_PCT),
    .CW        (CW)
  ) u_det (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (serial_mode),
    .rx       (pins_s[4]),
    .locked   (locked),
    .baud_idx (baud_idx)
  );
endmodule

// File: rtl/abd_checker.sv
module abd_checker #(
  parameter int NUM_RATES = 6
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      rst_pin,
  input logic                      psen_n,
  input logic                      load_mode,
  input logic                      serial_mode,
  input logic                      parallel_mode,
  input logic [abd_pkg::IDX_W-1:0] baud_idx,
  input logic                      locked
);
  a_r4_modes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(serial_mode && parallel_mode));

  a_r4_mode_needs_load: assert property (@(posedge clk) disable iff (!rst_n)
    (serial_mode || parallel_mode) |-> load_mode);

  a_r2_entry_pins: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(load_mode) |-> ($past(rst_pin, 3) && !$past(psen_n, 3)));

  a_r9_lock_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && serial_mode) |=> (locked && $stable(baud_idx)));

  a_r10_clear_on_exit: assert property (@(posedge clk) disable iff (!rst_n)
    !serial_mode |=> (!locked && baud_idx == '0));

  a_r6_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> (int'(baud_idx) < NUM_RATES));

  a_r5_lock_needs_serial: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(serial_mode));
endmodule

bind abd_bootstrap abd_checker #(.NUM_RATES(NUM_RATES)) u_chk (.*);

// File: tb/tb_abd_bootstrap.sv
`timescale 1ns/1ps
module tb_abd_bootstrap;
  localparam int unsigned CLK_HZ = 1_152_000;

  logic clk, rst_n, rst_pin, psen_n, strap_hi, strap_lo, rx_in;
  logic load_mode, serial_mode, parallel_mode, locked;
  logic [2:0] baud_idx;

  int n_chk, n_bad;

  abd_bootstrap #(.CLK_HZ(CLK_HZ)) dut (
    .clk(clk), .rst_n(rst_n), .rst_pin(rst_pin), .psen_n(psen_n),
    .strap_hi(strap_hi), .strap_lo(strap_lo), .rx_in(rx_in),
    .load_mode(load_mode), .serial_mode(serial_mode),
    .parallel_mode(parallel_mode), .baud_idx(baud_idx), .locked(locked)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic int bitw(input int idx);
    int bps;
    case (idx)
      0: bps = 300;   1: bps = 1200;  2: bps = 2400;
      3: bps = 9600;  4: bps = 19200; default: bps = 57600;
    endcase
    return (int'(CLK_HZ) + bps / 2) / bps;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input int w, input logic stopv);
    rx_in = 1'b0;
    wait_cyc(w);
    for (int i = 0; i < 8; i++) begin
      rx_in = d[i];
      wait_cyc(w);
    end
    rx_in = stopv;
    wait_cyc(w);
    rx_in = 1'b1;
    wait_cyc(2 * w);
  endtask

  task automatic enter_load(input logic hi, input logic lo);
    strap_hi = hi;
    strap_lo = lo;
    rst_pin  = 1'b1;
    psen_n   = 1'b0;
    wait_cyc(8);
    psen_n   = 1'b1;
    wait_cyc(4);
  endtask

  task automatic leave_load();
    rst_pin = 1'b0;
    wait_cyc(8);
  endtask

  task automatic t_reset();
    chk("R1 load_mode", load_mode, 0);
    chk("R1 serial_mode", serial_mode, 0);
    chk("R1 parallel_mode", parallel_mode, 0);
    chk("R1 locked", locked, 0);
    chk("R1 baud_idx", baud_idx, 0);
  endtask

  task automatic t_entry();
    strap_hi = 1'b1; strap_lo = 1'b1;
    rst_pin = 1'b1; psen_n = 1'b1;
    wait_cyc(8);
    chk("R2 rst only no entry", load_mode, 0);
    rst_pin = 1'b0; psen_n = 1'b0;
    wait_cyc(8);
    chk("R2 psen only no entry", load_mode, 0);
    rst_pin = 1'b1;
    wait_cyc(8);
    chk("R2 entry", load_mode, 1);
    psen_n = 1'b1;
    wait_cyc(8);
    chk("R3 hold after psen release", load_mode, 1);
    chk("R4 serial straps 11", serial_mode, 1);
    chk("R4 parallel off straps 11", parallel_mode, 0);
    strap_hi = 1'b0;
    wait_cyc(8);
    chk("R4 parallel straps 01", parallel_mode, 1);
    chk("R4 serial off straps 01", serial_mode, 0);
    strap_hi = 1'b1; strap_lo = 1'b0;
    wait_cyc(8);
    chk("R4 parallel straps 10", parallel_mode, 1);
    leave_load();
    chk("R3 exit on rst low", load_mode, 0);
    chk("R4 no flag outside load", serial_mode | parallel_mode, 0);
  endtask

  task automatic t_ignore();
    enter_load(1'b0, 1'b0);
    send_frame(8'h0D, bitw(3), 1'b1);
    chk("R5 no lock in parallel mode", locked, 0);
    leave_load();
  endtask

  task automatic t_rates();
    for (int k = 0; k < 6; k++) begin
      enter_load(1'b1, 1'b1);
      send_frame(8'h0D, bitw(k), 1'b1);
      chk("R6 locked at rate", locked, 1);
      chk("R6 index", baud_idx, k);
      leave_load();
      chk("R10 lock cleared", locked, 0);
      chk("R10 index cleared", baud_idx, 0);
    end
  endtask

  task automatic t_wrong_byte();
    enter_load(1'b1, 1'b1);
    send_frame(8'h41, bitw(3), 1'b1);
    chk("R7 wrong byte no lock", locked, 0);
    send_frame(8'h0D, bitw(3), 1'b1);
    chk("R7 rearm then lock", locked, 1);
    chk("R7 rearm index", baud_idx, 3);
    send_frame(8'h55, bitw(5), 1'b1);
    chk("R9 lock held", locked, 1);
    chk("R9 index held", baud_idx, 3);
    leave_load();
  endtask

  task automatic t_window();
    enter_load(1'b1, 1'b1);
    send_frame(8'h0D, 150, 1'b1);
    chk("R8 width between windows", locked, 0);
    send_frame(8'h0D, 125, 1'b1);
    chk("R8 width 4pct over", locked, 0);
    send_frame(8'h0D, 122, 1'b1);
    chk("R6 width inside window lock", locked, 1);
    chk("R6 width inside window index", baud_idx, 3);
    leave_load();
  endtask

  task automatic t_framing();
    enter_load(1'b1, 1'b1);
    send_frame(8'h0D, bitw(2), 1'b0);
    chk("R11 low stop no lock", locked, 0);
    send_frame(8'h0D, bitw(2), 1'b1);
    chk("R11 good frame after", locked, 1);
    chk("R11 index", baud_idx, 2);
    strap_lo = 1'b0;
    wait_cyc(8);
    chk("R10 clear on serial off", locked, 0);
    leave_load();
  endtask

  initial begin
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; rst_pin = 1'b0; psen_n = 1'b1;
    strap_hi = 1'b1; strap_lo = 1'b1; rx_in = 1'b1;
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(5);
    t_reset();
    t_entry();
    t_ignore();
    t_rates();
    t_wrong_byte();
    t_window();
    t_framing();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190_000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule